// File: doc/BRIEF.md
# Counter Byte Access and Latch Unit

This unit sits between an 8-bit register bus and one 16-bit counting element of a programmable interval timer channel. Software reaches a 16-bit count through single bytes. The unit gathers written bytes into the count register, which drives `init_count`. It pulses `count_ready` when a complete count has arrived. A separate read pointer serves bytes of either the live count or a frozen snapshot of it.

A snapshot request freezes the count at the moment of the request. A status request captures a byte that describes the channel. A null-count flag stays set from the moment a new count is written until the counter core reports that the count has been loaded. The counting itself takes place elsewhere. This unit only moves bytes, holds snapshots and keeps the flag.

Top module: `ctr_byte_port`

## Requirements
- R1: With access code 2'b01 (low byte only, `cfg_word[5:4]`), each written byte becomes `init_count[7:0]` and bit 15:8 become zero. With access code 2'b10 (high byte only), each written byte becomes `init_count[15:8]` and bit 7:0 become zero. Reads in these codes return the corresponding byte.
- R2: With access code 2'b11, the first write supplies the low byte and the second write supplies the high byte. `init_count` keeps its old value after the first write. After the second write both bytes change together. `count_ready` is high for exactly the one cycle that follows each completed count write.
- R3: While no count snapshot is held, reads return bytes of `live_count`. A count latch request freezes the value of `live_count` at that edge. That value is returned until every byte of the programmed format has been read. After that, reads follow `live_count` again.
- R4: A count latch request is ignored while a snapshot is still held. A status latch request is likewise ignored while a status byte is still held.
- R5: While a status byte is held, the next read returns it and releases it. Reads that follow return the held count, if there is one, and then the live count.
- R6: The status byte holds the `out_level` value in bit 7 and the null-count flag in bit 6, both sampled at the latch edge. Bits 5:0 hold the last accepted `cfg_word`.
- R7: The null-count flag is set by an accepted control word and by a completed count write. It is cleared by `load_pulse`. When a set and a clear fall in the same cycle, the set wins.
- R8: The write byte pointer and the read byte pointer advance independently. The sequence read low, write low, read high, write high returns both bytes correctly and loads both written bytes.
- R9: A control word is accepted when its access code is not 2'b00. An accepted control word discards any held snapshot and status, returns both pointers to the low byte, and overrides any write, read or latch in the same cycle. A control word with access code 2'b00 has no effect.
- R10: After reset the access code is 2'b01 and the stored mode bits are 0. Nothing is held, the null-count flag is 0, `init_count` is 0 and `count_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write for this channel |
| cfg_word | input | 6 | Access code [5:4], mode [3:1], BCD [0] |
| wr_en | input | 1 | Count byte write |
| wr_data | input | 8 | Count byte |
| rd_en | input | 1 | Read strobe; consumes the byte shown on rd_data |
| rd_data | output | 8 | Byte a read returns in this cycle |
| lat_cnt_req | input | 1 | Count latch request |
| lat_sts_req | input | 1 | Status latch request |
| live_count | input | 16 | Current value of the counting element |
| out_level | input | 1 | Current output level of the channel |
| load_pulse | input | 1 | Count register has been loaded into the counting element |
| init_count | output | 16 | Assembled count register |
| count_ready | output | 1 | One-cycle strobe after a complete count write |

## Verification
The hardest situation to reach from the ports is a status byte and a count snapshot held together while the two byte pointers sit at different positions, because reaching it needs a particular mix of half-finished reads and writes. Directed sequences build this state deliberately: they latch the count, then latch status, and also interleave half-written counts with half-read snapshots. A long run of random operations with a fixed seed then mixes control words, writes, reads, latches and load pulses. It compares every output byte in every cycle against a model built from the requirements.

// File: rtl/ctr_byte_port.sv
module ctr_byte_port #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [5:0]      cfg_word,
  input  logic            wr_en,
  input  logic [BW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [BW-1:0]   rd_data,
  input  logic            lat_cnt_req,
  input  logic            lat_sts_req,
  input  logic [2*BW-1:0] live_count,
  input  logic            out_level,
  input  logic            load_pulse,
  output logic [2*BW-1:0] init_count,
  output logic            count_ready
);
  localparam int CW = 2 * BW;
  localparam logic [1:0] ACC_LO = 2'b01;
  localparam logic [1:0] ACC_HI = 2'b10;
  localparam logic [1:0] ACC_WD = 2'b11;

  logic [1:0]    acc;
  logic [5:0]    prog;
  logic [BW-1:0] lo_buf, sts;
  logic [CW-1:0] cr, snap;
  logic          wr_hi, rd_hi, snap_held, sts_held, null_cnt, ready_q;

  wire cfg_ok  = cfg_we && (cfg_word[5:4] != 2'b00);
  wire wr_done = wr_en && (acc != ACC_WD || wr_hi);
  wire rd_done = rd_en && !sts_held && (acc != ACC_WD || rd_hi);
  wire rd_high = (acc == ACC_HI) || (acc == ACC_WD && rd_hi);
  wire [CW-1:0] src = snap_held ? snap : live_count;

  assign rd_data     = sts_held ? sts : (rd_high ? src[CW-1:BW] : src[BW-1:0]);
  assign init_count  = cr;
  assign count_ready = ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= ACC_LO; prog <= 6'b010000;
      lo_buf <= '0; sts <= '0; cr <= '0; snap <= '0;
      wr_hi <= 1'b0; rd_hi <= 1'b0; snap_held <= 1'b0; sts_held <= 1'b0;
      null_cnt <= 1'b0; ready_q <= 1'b0;
    end else if (cfg_ok) begin
      acc <= cfg_word[5:4]; prog <= cfg_word;
      wr_hi <= 1'b0; rd_hi <= 1'b0; snap_held <= 1'b0; sts_held <= 1'b0;
      null_cnt <= 1'b1; ready_q <= 1'b0;
    end else begin
      ready_q <= wr_done;
      if (wr_en) begin
        case (acc)
          ACC_LO: cr <= {{BW{1'b0}}, wr_data};
          ACC_HI: cr <= {wr_data, {BW{1'b0}}};
          default: begin
            if (wr_hi) cr <= {wr_data, lo_buf};
            else lo_buf <= wr_data;
            wr_hi <= !wr_hi;
          end
        endcase
      end
      if (wr_done) null_cnt <= 1'b1;
      else if (load_pulse) null_cnt <= 1'b0;
      if (rd_en) begin
        if (sts_held) sts_held <= 1'b0;
        else if (acc == ACC_WD) rd_hi <= !rd_hi;
      end
      if (rd_done) snap_held <= 1'b0;
      if (lat_cnt_req && !snap_held) begin
        snap <= live_count; snap_held <= 1'b1;
      end
      if (lat_sts_req && !sts_held) begin
        sts <= BW'({out_level, null_cnt, prog}); sts_held <= 1'b1;
      end
    end
  end

  a_r2_ready_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    count_ready |-> $past(wr_en));
  a_r1_single_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ready && acc == ACC_LO) |-> (init_count[CW-1:BW] == '0));
  a_r7_null_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    count_ready |-> null_cnt);
  a_r2_first_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_WD && wr_en && !wr_hi && !cfg_we) |=> $stable(init_count));
  a_r6_status_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_held) |-> (rd_data[5:0] == prog));
  a_r3_snapshot_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_held && !sts_held && !rd_en && !cfg_we && !lat_sts_req) |=> $stable(rd_data));
endmodule

// File: tb/test_ctr_byte_port.sv
`timescale 1ns/1ps
module test_ctr_byte_port;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, wr_en = 0, rd_en = 0, lat_cnt_req = 0, lat_sts_req = 0;
  logic out_level = 0, load_pulse = 0;
  logic [5:0] cfg_word = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] live_count = 0, init_count;
  logic count_ready;
  int checks = 0, errors = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  ctr_byte_port i_ctr_byte_port (.clk, .rst_n, .cfg_we, .cfg_word, .wr_en, .wr_data,
    .rd_en, .rd_data, .lat_cnt_req, .lat_sts_req, .live_count, .out_level,
    .load_pulse, .init_count, .count_ready);

  logic [1:0] m_acc; logic [5:0] m_prog; logic [7:0] m_lo, m_sts;
  logic [15:0] m_cr, m_snap; logic m_wrhi, m_rdhi, m_snh, m_sth, m_null, m_rdy;

  task automatic m_reset();
    m_acc = 2'b01; m_prog = 6'b010000; m_lo = 0; m_sts = 0; m_cr = 0; m_snap = 0;
    m_wrhi = 0; m_rdhi = 0; m_snh = 0; m_sth = 0; m_null = 0; m_rdy = 0;
  endtask

  function automatic logic [7:0] exp_rd();
    logic [15:0] s = m_snh ? m_snap : live_count;
    if (m_sth) return m_sts;
    if (m_acc == 2'b10 || (m_acc == 2'b11 && m_rdhi)) return s[15:8];
    return s[7:0];
  endfunction

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic m_update();
    logic wd, rdn;
    if (cfg_we && cfg_word[5:4] != 0) begin
      m_acc = cfg_word[5:4]; m_prog = cfg_word; m_wrhi = 0; m_rdhi = 0;
      m_snh = 0; m_sth = 0; m_null = 1; m_rdy = 0; return;
    end
    wd = wr_en && (m_acc != 2'b11 || m_wrhi);
    rdn = rd_en && !m_sth && (m_acc != 2'b11 || m_rdhi);
    if (lat_sts_req && !m_sth) m_sts = {out_level, m_null, m_prog};
    if (lat_cnt_req && !m_snh) m_snap = live_count;
    if (wr_en) begin
      if (m_acc == 2'b01) m_cr = {8'h00, wr_data};
      else if (m_acc == 2'b10) m_cr = {wr_data, 8'h00};
      else begin
        if (m_wrhi) m_cr = {wr_data, m_lo}; else m_lo = wr_data;
        m_wrhi = !m_wrhi;
      end
    end
    if (wd) m_null = 1; else if (load_pulse) m_null = 0;
    if (rd_en) begin
      if (m_sth) m_sth = 0; else if (m_acc == 2'b11) m_rdhi = !m_rdhi;
    end
    if (rdn) m_snh = 0;
    if (lat_cnt_req && !m_snh) m_snh = 1;
    if (lat_sts_req && !m_sth) m_sth = 1;
    m_rdy = wd;
  endtask

  task automatic step(bit cw, logic [5:0] cwd, bit we, logic [7:0] d, bit re,
                      bit lc, bit ls, bit ld, logic [15:0] live, bit o);
    cfg_we = cw; cfg_word = cwd; wr_en = we; wr_data = d; rd_en = re;
    lat_cnt_req = lc; lat_sts_req = ls; load_pulse = ld; live_count = live; out_level = o;
    #1;
    chk(tag, {8'h00, rd_data}, {8'h00, exp_rd()}, "rd_data");
    chk(tag, init_count, m_cr, "init_count");
    chk(tag, {15'h0, count_ready}, {15'h0, m_rdy}, "count_ready");
    m_update();
    @(negedge clk);
  endtask

  task automatic idle(logic [15:0] live); step(0,0,0,0,0,0,0,0,live,0); endtask
  task automatic cfg(logic [5:0] w);      step(1,w,0,0,0,0,0,0,16'h0,0); endtask
  task automatic wr(logic [7:0] d);       step(0,0,1,d,0,0,0,0,16'h0,0); endtask
  task automatic rd(logic [15:0] live);   step(0,0,0,0,1,0,0,0,live,0); endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10"; idle(16'h1234);
    tag = "R1"; cfg(6'b100000); wr(8'hA5); idle(16'h5A77);
    cfg(6'b010110); wr(8'h3C); idle(16'h0102);
    tag = "R2"; cfg(6'b110100); wr(8'h11); idle(0); wr(8'h22); idle(0);
    tag = "R3"; step(0,0,0,0,0,1,0,0,16'hABCD,0); idle(16'h9999);
    tag = "R4"; step(0,0,0,0,0,1,0,0,16'h1111,0);
    tag = "R3"; rd(16'h2222); rd(16'h3333); rd(16'h4567); rd(16'h4567);
    tag = "R7"; cfg(6'b110110); step(0,0,0,0,0,0,1,0,16'h0,1);
    tag = "R6"; rd(0);
    tag = "R7"; step(0,0,0,0,0,0,0,1,0,0); step(0,0,0,0,0,0,1,0,0,0); rd(0);
    wr(8'h01); step(0,0,1,8'h02,0,0,0,1,0,0); step(0,0,0,0,0,0,1,0,0,0); rd(0);
    tag = "R5"; step(0,0,0,0,0,1,0,0,16'hBEEF,0); step(0,0,0,0,0,1,1,0,16'h0,1);
    tag = "R4"; step(0,0,0,0,0,0,1,0,16'h0,0);
    tag = "R5"; rd(0); rd(0); rd(0); rd(16'h7654);
    tag = "R8"; step(0,0,0,0,0,1,0,0,16'hC0DE,0); rd(0); wr(8'h44); rd(0); wr(8'h55); idle(0);
    tag = "R9"; step(0,0,0,0,0,1,1,0,16'hF00D,0); cfg(6'b000000); rd(0);
    cfg(6'b110000); rd(16'h8642); wr(8'h66); cfg(6'b110000); wr(8'h77); wr(8'h88); idle(0);
    step(1,6'b010000,1,8'h99,1,1,1,0,16'h1357,1); idle(16'h2468);
    begin
      process::self().srandom(32'd20240601);
      for (int i = 0; i < 4000; i++) begin
        int op = $urandom_range(0, 9);
        logic [15:0] lv = 16'($urandom);
        logic [7:0] d = 8'($urandom);
        bit o = 1'($urandom);
        tag = (op < 2) ? "R8" : (m_sth ? "R5" : (m_snh ? "R3" : "R2"));
        case (op)
          0: step(1, 6'($urandom), 0, 0, 0, 0, 0, 0, lv, o);
          1, 2: step(0, 0, 1, d, 0, 0, 0, 1'($urandom), lv, o);
          3, 4: step(0, 0, 0, 0, 1, 0, 0, 0, lv, o);
          5: step(0, 0, 0, 0, 0, 1, 0, 0, lv, o);
          6: step(0, 0, 0, 0, 0, 0, 1, 0, lv, o);
          7: step(0, 0, 0, 0, 0, 1, 1, 0, lv, o);
          8: step(0, 0, 0, 0, 0, 0, 0, 1, lv, o);
          default: step(0, 0, 1, d, 1, 0, 0, 0, lv, o);
        endcase
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule